// File: doc/BRIEF.md
# Master Interrupt Aggregator with Message Trigger

This block sits at the root of a two-level interrupt tree. Eleven child groups each present a 32-bit vector of their pending, enabled interrupt causes. The block reduces those vectors into a 32-bit master status word. Each mirrored bit is the OR of a fixed sub-field of one child. Bit 31 of the word is a software-written global enable. All other bits are status only.

When the global enable is on and any status bit is set, the block raises a one-cycle trigger pulse toward a message-signalled interrupt engine. The pulse is gated by a 16-bit message control word, which must select the single supported format with the enable bit on. It is also gated by an attached input. The pulse fires when the enable-and-pending condition first becomes true. The condition is also re-checked, and can fire again, after every write to the master word and after every rescan strobe. Child groups raise the rescan strobe when their masks or enables change or when a new event is injected.

Top module: `irq_master_agg`

## Requirements
- R1: Reset clears `master_o` and `trig_o`. A write (`wr_en_i` = 1) sets bit 31 of `master_o` to `wr_data_i[31]` one cycle later. Bits 30:0 of the write data are ignored, and bit 31 keeps its value when no write occurs.
- R2: Engine groups are group indices 0 to 3 of `grp_pend_i`. Group g occupies bits g*32+31 down to g*32. Master bit 0 is the OR of group 0 bits 15:0 and bit 1 is the OR of group 0 bits 31:16. Bits 2 and 3 are the same two halves of group 1. Bit 4 is the OR of group 2 bits 15:0, and bit 6 is the OR of group 3 bits 15:0. Each status bit follows its source one cycle later, both setting and clearing.
- R3: Master bits 16, 17 and 18 are the OR of all 32 bits of groups 4, 5 and 6. Master bits 20, 22, 23 and 30 are the OR of all 32 bits of groups 7, 8, 9 and 10 respectively. Each follows its source with one cycle of latency.
- R4: Master bits 5, 7 to 15, 19, 21 and 24 to 29 always read 0. Bits 31:16 of groups 2 and 3 affect no master bit and produce no trigger.
- R5: While master bit 31 is 0, `trig_o` stays 0, whatever the status bits, writes or rescans.
- R6: `trig_o` can only be 1 when `msi_ctrl_i` equals 16'h0001, that is, bit 0 set and bits 15:1 clear. Any other value suppresses the pulse.
- R7: `trig_o` can only be 1 when `attached_i` was 1 in the preceding cycle. With `attached_i` at 0 the condition is still tracked, but no pulse is issued.
- R8: When the condition "bit 31 set and any of bits 30:0 set" goes from false to true, `trig_o` pulses high for exactly one cycle, two cycles after the child input or write that caused it. It then returns to 0 while the condition merely persists.
- R9: A rescan strobe (`rescan_i`) or any master write, made while the condition holds, produces a fresh one-cycle pulse two cycles after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_pend_i | input | 352 | Pending-and-enabled causes of the 11 child groups, 32 bits each, group g at bits g*32+31:g*32 |
| wr_en_i | input | 1 | Master word write strobe |
| wr_data_i | input | 32 | Master word write data; only bit 31 is used |
| rescan_i | input | 1 | Re-evaluation strobe from child mask, enable or event activity |
| msi_ctrl_i | input | 16 | Message control word; bit 0 enable, bits 15:1 format |
| attached_i | input | 1 | Consumer attached; gates pulse emission |
| master_o | output | 32 | Master word: bit 31 enable, other bits mirrored status |
| trig_o | output | 1 | One-cycle message trigger pulse |

## Verification
The status bits of `master_o` and the enable bit are due one clock edge after the input or write that changes them. The bench drives on the falling edge and reads them at the next falling edge. A trigger passes through two registers, so it is due at the second rising edge after its cause. The bench therefore reads `trig_o` after one edge, expecting 0, then after the second edge, expecting the pulse, and after a third edge, expecting it gone. The child-to-master mapping is swept one bit at a time over all 352 child bits, against a bench-side table of master bit positions.

// File: rtl/irq_master_pkg.sv
package irq_master_pkg;

  localparam int MW      = 32;
  localparam int NGRP    = 11;
  localparam int EN_BIT  = 31;
  localparam int GRP_IDW = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_ALL  = 2'd3
  } field_sel_e;

  typedef struct packed {
    field_sel_e           sel;
    logic [GRP_IDW-1:0]   grp;
  } route_t;

  // Which child group and which sub-field feeds a given master status bit.
  function automatic route_t route_of(input int bitpos);
    route_t r;
    r.sel = SEL_NONE;
    r.grp = '0;
    case (bitpos)
      0:  begin r.sel = SEL_LO;  r.grp = 4'd0;  end
      1:  begin r.sel = SEL_HI;  r.grp = 4'd0;  end
      2:  begin r.sel = SEL_LO;  r.grp = 4'd1;  end
      3:  begin r.sel = SEL_HI;  r.grp = 4'd1;  end
      4:  begin r.sel = SEL_LO;  r.grp = 4'd2;  end
      6:  begin r.sel = SEL_LO;  r.grp = 4'd3;  end
      16: begin r.sel = SEL_ALL; r.grp = 4'd4;  end
      17: begin r.sel = SEL_ALL; r.grp = 4'd5;  end
      18: begin r.sel = SEL_ALL; r.grp = 4'd6;  end
      20: begin r.sel = SEL_ALL; r.grp = 4'd7;  end
      22: begin r.sel = SEL_ALL; r.grp = 4'd8;  end
      23: begin r.sel = SEL_ALL; r.grp = 4'd9;  end
      30: begin r.sel = SEL_ALL; r.grp = 4'd10; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_mirror.sv
module irq_mirror
  import irq_master_pkg::*;
#(
  parameter int W    = MW,
  parameter int NG   = NGRP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NG*W-1:0] grp_pend_i,
  output logic [W-2:0]    sum_q
);

  localparam int HALF = W / 2;
  localparam int SW   = W - 1;

  logic [SW-1:0] sum_d;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    localparam route_t RT = route_of(b);
    localparam int     GB = int'(RT.grp) * W;
    if (RT.sel == SEL_LO) begin : g_lo
      assign sum_d[b] = |grp_pend_i[GB +: HALF];
    end else if (RT.sel == SEL_HI) begin : g_hi
      assign sum_d[b] = |grp_pend_i[GB+HALF +: HALF];
    end else if (RT.sel == SEL_ALL) begin : g_all
      assign sum_d[b] = |grp_pend_i[GB +: W];
    end else begin : g_none
      assign sum_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W      = 32,
  parameter int EN_POS = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rescan_i,
  output logic         en_q,
  output logic         eval_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      eval_q <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= wr_data_i[EN_POS];
      eval_q <= wr_en_i | rescan_i;
    end
  end

endmodule

// File: rtl/irq_trig.sv
module irq_trig #(
  parameter int SW    = 31,
  parameter int CTRLW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    sum_i,
  input  logic             en_i,
  input  logic             eval_i,
  input  logic [CTRLW-1:0] msi_ctrl_i,
  input  logic             attached_i,
  output logic             trig_o
);

  localparam logic [CTRLW-1:0] CTRL_OK = CTRLW'(1);

  logic core;
  logic core_q;
  logic gate;

  assign core = en_i & (|sum_i);
  assign gate = (msi_ctrl_i == CTRL_OK) & attached_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_q <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      core_q <= core;
      trig_o <= core & gate & (~core_q | eval_i);
    end
  end

endmodule

// File: rtl/irq_master_agg.sv
module irq_master_agg
  import irq_master_pkg::*;
#(
  parameter int W     = MW,
  parameter int NG    = NGRP,
  parameter int CTRLW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NG*W-1:0] grp_pend_i,
  input  logic            wr_en_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic            rescan_i,
  input  logic [CTRLW-1:0] msi_ctrl_i,
  input  logic            attached_i,
  output logic [W-1:0]    master_o,
  output logic            trig_o
);

  localparam int SW = W - 1;

  logic [SW-1:0] sum_q;
  logic          en_q;
  logic          eval_q;

  irq_mirror #(.W(W), .NG(NG)) u_mirror (
    .clk        (clk),
    .rst        (rst),
    .grp_pend_i (grp_pend_i),
    .sum_q      (sum_q)
  );

  irq_enable_reg #(.W(W), .EN_POS(W-1)) u_en (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rescan_i  (rescan_i),
    .en_q      (en_q),
    .eval_q    (eval_q)
  );

  irq_trig #(.SW(SW), .CTRLW(CTRLW)) u_trig (
    .clk        (clk),
    .rst        (rst),
    .sum_i      (sum_q),
    .en_i       (en_q),
    .eval_i     (eval_q),
    .msi_ctrl_i (msi_ctrl_i),
    .attached_i (attached_i),
    .trig_o     (trig_o)
  );

  assign master_o = {en_q, sum_q};

endmodule

// File: rtl/irq_master_agg_chk.sv
module irq_master_agg_chk #(
  parameter int W     = 32,
  parameter int NG    = 11,
  parameter int CTRLW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [NG*W-1:0] grp_pend_i,
  input logic            wr_en_i,
  input logic [W-1:0]    wr_data_i,
  input logic [CTRLW-1:0] msi_ctrl_i,
  input logic            attached_i,
  input logic [W-1:0]    master_o,
  input logic            trig_o
);

  // R1
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> master_o[W-1] == $past(wr_data_i[W-1]));

  // R1
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(master_o[W-1]));

  // R3
  pipe0_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> master_o[16] == (|$past(grp_pend_i[4*W +: W])));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    master_o[15:7] == '0 && master_o[5] == 1'b0);

  // R5
  trig_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(master_o[W-1]));

  // R6
  trig_needs_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(msi_ctrl_i) == CTRLW'(1));

  // R7
  trig_needs_att_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(attached_i));

  // R8
  trig_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(|master_o[W-2:0]));

endmodule

bind irq_master_agg irq_master_agg_chk #(.W(W), .NG(NG), .CTRLW(CTRLW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .grp_pend_i (grp_pend_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .msi_ctrl_i (msi_ctrl_i),
  .attached_i (attached_i),
  .master_o   (master_o),
  .trig_o     (trig_o)
);

// File: tb/irq_master_agg_tb.sv
module irq_master_agg_tb;

  localparam int NG = 11;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [NG*W-1:0] pend;
  logic            wr_en;
  logic [W-1:0]    wr_data;
  logic            rescan;
  logic [15:0]     msi;
  logic            att;
  logic [W-1:0]    master;
  logic            trig;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_master_agg u_dut (
    .clk        (clk),
    .rst        (rst),
    .grp_pend_i (pend),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rescan_i   (rescan),
    .msi_ctrl_i (msi),
    .attached_i (att),
    .master_o   (master),
    .trig_o     (trig)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Bench-side position of the master bit driven by group g, bit b (-1: none).
  function automatic int exp_pos(input int g, input int b);
    case (g)
      0: return (b < 16) ? 0 : 1;
      1: return (b < 16) ? 2 : 3;
      2: return (b < 16) ? 4 : -1;
      3: return (b < 16) ? 6 : -1;
      4: return 16;
      5: return 17;
      6: return 18;
      7: return 20;
      8: return 22;
      9: return 23;
      default: return 30;
    endcase
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_expect(input bit exp1, input string req);
    // cause applied and one edge already passed
    chk(trig == 1'b0, req, {31'd0, trig}, 32'd0);
    step();
    chk(trig == exp1, req, {31'd0, trig}, {31'd0, exp1});
    step();
    chk(trig == 1'b0, req, {31'd0, trig}, 32'd0);
  endtask

  task automatic do_rescan(input bit exp1, input string req);
    rescan = 1'b1;
    step();
    rescan = 1'b0;
    pulse_expect(exp1, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pend = '0; wr_en = 1'b0; wr_data = '0; rescan = 1'b0;
    msi = 16'h0001; att = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(master == '0, "R1 reset master", master, '0);
    chk(trig == 1'b0, "R1 reset trig", {31'd0, trig}, 32'd0);

    // R2 R3 R4 R5: sweep every child bit with enable off
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < W; b++) begin
        logic [31:0] e;
        int p;
        pend = '0;
        pend[g*W + b] = 1'b1;
        step();
        p = exp_pos(g, b);
        e = (p < 0) ? 32'd0 : (32'd1 << p);
        chk(master == e, (g < 4) ? "R2 R4 mirror" : "R3 mirror", master, e);
        chk(trig == 1'b0, "R5 no trig when disabled", {31'd0, trig}, 32'd0);
      end
    end
    pend = '0;
    step();
    chk(master == '0, "R2 clear follows child", master, '0);

    // R1 write ignores low bits
    wr(32'h7FFF_FFFF);
    chk(master == '0, "R1 low bits ignored", master, '0);
    wr(32'h8000_0000);
    chk(master == 32'h8000_0000, "R1 enable set", master, 32'h8000_0000);
    step();
    chk(master == 32'h8000_0000, "R1 enable held", master, 32'h8000_0000);
    chk(trig == 1'b0, "R8 no pulse without pending", {31'd0, trig}, 32'd0);

    // R8 rising edge pulse
    pend[7*W + 5] = 1'b1;
    step();
    chk(master == 32'h8010_0000, "R3 port bit", master, 32'h8010_0000);
    pulse_expect(1'b1, "R8 rising pulse");
    step();
    chk(trig == 1'b0, "R8 no repeat while held", {31'd0, trig}, 32'd0);

    // R9 rescan re-fires
    do_rescan(1'b1, "R9 rescan pulse");

    // R6 format gating
    msi = 16'h0003;
    do_rescan(1'b0, "R6 format bits set");
    msi = 16'h0000;
    do_rescan(1'b0, "R6 enable bit clear");
    msi = 16'h8001;
    do_rescan(1'b0, "R6 top format bit");
    msi = 16'h0001;

    // R7 attached gating
    att = 1'b0;
    do_rescan(1'b0, "R7 detached");
    att = 1'b1;
    step(); step();
    chk(trig == 1'b0, "R7 attach alone no pulse", {31'd0, trig}, 32'd0);

    // R5 disable, then R9 write with pending
    wr(32'h7FFF_FFFF);
    chk(master == 32'h0010_0000, "R1 enable cleared", master, 32'h0010_0000);
    do_rescan(1'b0, "R5 rescan while disabled");
    wr_en = 1'b1; wr_data = 32'h8000_0000;
    step();
    wr_en = 1'b0; wr_data = '0;
    pulse_expect(1'b1, "R9 write re-evaluates");
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    step();
    wr_en = 1'b0; wr_data = '0;
    pulse_expect(1'b1, "R9 write while enabled");

    // R4 unmapped halves with enable on
    pend = '0;
    step(); step();
    pend[2*W + 20] = 1'b1;
    pend[3*W + 31] = 1'b1;
    step();
    chk(master == 32'h8000_0000, "R4 unmapped half", master, 32'h8000_0000);
    pulse_expect(1'b0, "R4 no trig from unmapped");

    // R2 engine low half re-rise
    pend = '0;
    pend[1*W + 3] = 1'b1;
    step();
    chk(master == 32'h8000_0004, "R2 group1 low", master, 32'h8000_0004);
    pulse_expect(1'b1, "R8 pulse from engine bit");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule